// File: doc/BRIEF.md
# Truncated Fourier Series Evaluator

This block evaluates a sixteen-term trigonometric series at one point after another around a circle. Each term is the sum of a cosine product and a sine product. Each product pairs a stored coefficient, scaled by a per-term weight, with an 8-bit value from an internal phase-to-amplitude lookup. The coefficient tables sit in an internal ROM. A single multiply-accumulate datapath is shared by all terms, in time order.

A two-state controller steps a term counter. The low bits of that counter address the coefficient ROM and also form the phase of the term, so both reach the arithmetic stages in the same cycle. The first term of a point reloads the accumulator. On the last term, the finished sum goes straight to the output register. The block produces one 40-bit result every sixteen enabled cycles. A single clock enable freezes the whole block when it is low.

Controller states: `S_IDLE`, entered by reset, which issues nothing. `S_ISSUE` issues one term per enabled cycle. Transitions: `S_IDLE` to `S_ISSUE` on the first enabled cycle. `S_ISSUE` to `S_ISSUE` on every enabled cycle, and the term counter wraps after the sixteenth term. Any state returns to `S_IDLE` on reset.

Top module: `trig_series_eval`

## Requirements
- R1: A synchronous reset (`rst` high) drives `y_valid` to 0 and `y_data` to 0 at the next edge. It also returns the controller to `S_IDLE`, the term counter to 0 and the base phase to 0.
- R2: The 8-bit sine lookup is computed as follows. For phase p (0..255), take h = p mod 128 and m = floor(h·(128−h)·127/4096). The result is m when p < 128 and −m otherwise. The cosine of p is the sine of (p+64) mod 256.
- R3: For term k = 1..16 the ROM holds three 16-bit two's complement words: A_k = (7919·k+311) mod 2^16, B_k = (4093·k+2027) mod 2^16 and W_k = (911·k+5) mod 2^16. The 32-bit multiplier operands are A_k·W_k and B_k·W_k.
- R4: Each result equals Σ_{k=1..16} (A_k·W_k·cos(φ_k) + B_k·W_k·sin(φ_k)) modulo 2^40, in two's complement, with φ_k = (k·θ) mod 256.
- R5: For the n-th result after reset (n = 0 first), the base phase θ = (n·13) mod 256, where 13 is the default phase step. The base phase wraps modulo 256.
- R6: With results after the first, exactly 16 enabled cycles separate consecutive `y_valid` pulses, and each pulse lasts one cycle.
- R7: The first `y_valid` follows on the 21st enabled clock edge after reset is released.
- R8: A clock edge with `en` low has no effect. No `y_valid` appears after it, `y_data` is unchanged, and the sequence of results and their values match an uninterrupted run.
- R9: `y_data` holds the last result while `y_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the whole block |
| y_data | output | 40 | Series value, signed two's complement |
| y_valid | output | 1 | One-cycle strobe marking a new `y_data` |

## Verification
The series is first checked with the enable held high. That run sets the result interval and the first-result latency. The same sequence is then run with the enable gated at several duty cycles (alternate edges, one edge in four, one edge dropped in eight). Equal values there show that a disabled edge freezes every stage, not just the counter. The run spans enough points for the base phase to wrap past 255, which separates a modulo-256 phase from a wider one. A reset in the middle of a point then shows that the accumulator, phase and counter all restart, because the next result must equal the point-zero value again.

// File: rtl/tse_pkg.sv
package tse_pkg;
    localparam int PH_W     = 8;
    localparam int AMP_W    = 8;
    localparam int COEF_W   = 16;
    localparam int OP_W     = 2 * COEF_W;
    localparam int ACC_W    = 40;
    localparam int PH_HALF  = 1 << (PH_W - 1);
    localparam int PH_QTR   = 1 << (PH_W - 2);
    localparam int AMP_PEAK = (1 << (AMP_W - 1)) - 1;

    typedef logic        [PH_W-1:0]   phase_t;
    typedef logic signed [AMP_W-1:0]  amp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [OP_W-1:0]   op_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic v;
        logic first;
        logic last;
    } tag_t;

    // Parabolic half-wave sine, R2
    function automatic amp_t sine_lu(input phase_t p);
        int h;
        int m;
        h = int'(p[PH_W-2:0]);
        m = (h * (PH_HALF - h) * AMP_PEAK) / (PH_HALF * PH_HALF / 4);
        if (p[PH_W-1]) m = -m;
        return amp_t'(m);
    endfunction

    // Coefficient contents, R3
    function automatic coef_t coef_cos(input int k);
        return coef_t'(k * 7919 + 311);
    endfunction

    function automatic coef_t coef_sin(input int k);
        return coef_t'(k * 4093 + 2027);
    endfunction

    function automatic coef_t coef_wgt(input int k);
        return coef_t'(k * 911 + 5);
    endfunction
endpackage

// File: rtl/tse_ctrl.sv
module tse_ctrl
    import tse_pkg::*;
#(
    parameter int N_TERMS    = 16,
    parameter int CNT_W      = $clog2(N_TERMS),
    parameter int PHASE_STEP = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic             iss_v,
    output logic [CNT_W-1:0] iss_idx,
    output phase_t           iss_ph,
    output logic             iss_first,
    output logic             iss_last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_TERMS - 1);
    localparam phase_t           STEP     = PH_W'(PHASE_STEP);

    typedef enum logic [0:0] {S_IDLE, S_ISSUE} st_t;

    st_t              st, st_nx;
    logic [CNT_W-1:0] cnt;
    phase_t           theta;
    phase_t           kx;

    // state register
    always_ff @(posedge clk) begin
        if (rst)     st <= S_IDLE;
        else if (en) st <= st_nx;
    end

    always_comb begin
        unique case (st)
            S_IDLE:  st_nx = S_ISSUE;
            S_ISSUE: st_nx = S_ISSUE;
        endcase
    end

    // term counter and base phase
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            theta <= '0;
        end else if (en && st == S_ISSUE) begin
            if (cnt == LAST_IDX) begin
                cnt   <= '0;
                theta <= theta + STEP;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        kx        = PH_W'(cnt) + PH_W'(1);
        iss_v     = en && (st == S_ISSUE);
        iss_idx   = cnt;
        iss_ph    = kx * theta;
        iss_first = (cnt == '0);
        iss_last  = (cnt == LAST_IDX);
    end
endmodule

// File: rtl/tse_trig.sv
module tse_trig
    import tse_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  phase_t ph_i,
    output amp_t   cos_o,
    output amp_t   sin_o
);
    phase_t ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            cos_o <= '0;
            sin_o <= '0;
        end else if (en) begin
            ph_q  <= ph_i;
            sin_o <= sine_lu(ph_q);
            cos_o <= sine_lu(ph_q + PH_W'(PH_QTR));
        end
    end
endmodule

// File: rtl/tse_coef_rom.sv
module tse_coef_rom
    import tse_pkg::*;
#(
    parameter int N_TERMS = 16,
    parameter int CNT_W   = $clog2(N_TERMS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] addr_i,
    output op_t              opa_o,
    output op_t              opb_o
);
    coef_t rom_a [N_TERMS];
    coef_t rom_b [N_TERMS];
    coef_t rom_w [N_TERMS];
    coef_t a_q, b_q, w_q;

    for (genvar g = 0; g < N_TERMS; g++) begin : g_rom
        assign rom_a[g] = coef_cos(g + 1);
        assign rom_b[g] = coef_sin(g + 1);
        assign rom_w[g] = coef_wgt(g + 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            w_q   <= '0;
            opa_o <= '0;
            opb_o <= '0;
        end else if (en) begin
            a_q   <= rom_a[addr_i];
            b_q   <= rom_b[addr_i];
            w_q   <= rom_w[addr_i];
            opa_o <= OP_W'(a_q) * OP_W'(w_q);
            opb_o <= OP_W'(b_q) * OP_W'(w_q);
        end
    end
endmodule

// File: rtl/tse_mac.sv
module tse_mac
    import tse_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  tag_t tag_i,
    input  op_t  opa_i,
    input  op_t  opb_i,
    input  amp_t cos_i,
    input  amp_t sin_i,
    output acc_t y_o,
    output logic y_valid_o
);
    acc_t pc, ps, sm, acc;
    tag_t t3, t4;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            ps <= '0;
            sm <= '0;
            t3 <= '0;
            t4 <= '0;
        end else if (en) begin
            pc <= ACC_W'(opa_i) * ACC_W'(cos_i);
            ps <= ACC_W'(opb_i) * ACC_W'(sin_i);
            t3 <= tag_i;
            sm <= pc + ps;
            t4 <= t3;
        end
    end

    // reload on first term, bypass to output on last term
    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            y_o       <= '0;
            y_valid_o <= 1'b0;
        end else if (en) begin
            y_valid_o <= t4.v && t4.last;
            if (t4.v) begin
                acc <= t4.first ? sm : acc + sm;
                if (t4.last) y_o <= acc + sm;
            end
        end else begin
            y_valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/trig_series_eval.sv
module trig_series_eval
    import tse_pkg::*;
#(
    parameter int N_TERMS    = 16,
    parameter int PHASE_STEP = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [ACC_W-1:0] y_data,
    output logic             y_valid
);
    localparam int CNT_W = $clog2(N_TERMS);

    logic             iss_v, iss_first, iss_last;
    logic [CNT_W-1:0] iss_idx;
    phase_t           iss_ph;
    amp_t             cos_v, sin_v;
    op_t              opa, opb;
    tag_t             tag1, tag2;
    acc_t             y_s;

    tse_ctrl #(.N_TERMS(N_TERMS), .CNT_W(CNT_W), .PHASE_STEP(PHASE_STEP)) u_ctrl (
        .clk(clk), .rst(rst), .en(en),
        .iss_v(iss_v), .iss_idx(iss_idx), .iss_ph(iss_ph),
        .iss_first(iss_first), .iss_last(iss_last)
    );

    tse_trig u_trig (
        .clk(clk), .rst(rst), .en(en),
        .ph_i(iss_ph), .cos_o(cos_v), .sin_o(sin_v)
    );

    tse_coef_rom #(.N_TERMS(N_TERMS), .CNT_W(CNT_W)) u_rom (
        .clk(clk), .rst(rst), .en(en),
        .addr_i(iss_idx), .opa_o(opa), .opb_o(opb)
    );

    // term tags follow the two-cycle lookup latency
    always_ff @(posedge clk) begin
        if (rst) begin
            tag1 <= '0;
            tag2 <= '0;
        end else if (en) begin
            tag1 <= '{v: iss_v, first: iss_first, last: iss_last};
            tag2 <= tag1;
        end
    end

    tse_mac u_mac (
        .clk(clk), .rst(rst), .en(en),
        .tag_i(tag2), .opa_i(opa), .opb_i(opb),
        .cos_i(cos_v), .sin_i(sin_v),
        .y_o(y_s), .y_valid_o(y_valid)
    );

    assign y_data = y_s;
endmodule

// File: rtl/tse_chk.sv
module tse_chk #(
    parameter int N_TERMS = 16,
    parameter int ACC_W   = 40
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             y_valid,
    input logic [ACC_W-1:0] y_data
);
    int   gap;
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= 0;
            seen <= 1'b0;
        end else if (y_valid) begin
            gap  <= en ? 1 : 0;
            seen <= 1'b1;
        end else if (en) begin
            gap <= gap + 1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!y_valid && y_data == '0));

    p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
        y_valid |=> !y_valid);

    p_interval_r6: assert property (@(posedge clk) disable iff (rst)
        (y_valid && seen) |-> (gap == N_TERMS));

    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !y_valid);

    p_hold_data_r9: assert property (@(posedge clk) disable iff (rst)
        !y_valid |-> $stable(y_data));
endmodule

bind trig_series_eval tse_chk #(.N_TERMS(N_TERMS), .ACC_W(tse_pkg::ACC_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .y_valid(y_valid), .y_data(y_data)
);

// File: tb/sim_trig_series_eval.sv
module sim_trig_series_eval;
    localparam int CLK_P = 10;
    localparam int STEP  = 13;
    localparam int NT    = 16;
    // stimulus vectors: {enable mask, points to collect}
    localparam logic [15:0] VEC [5] = '{
        {8'hFF, 8'd4}, {8'h55, 8'd4}, {8'h11, 8'd3}, {8'hEF, 8'd5}, {8'hFF, 8'd10}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [39:0] y_data;
    logic        y_valid;

    int checks = 0;
    int errors = 0;
    int pt     = 0;
    int encnt  = 0;
    logic [39:0] last_y = '0;

    trig_series_eval u0 (.clk(clk), .rst(rst), .en(en), .y_data(y_data), .y_valid(y_valid));

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sn(input int p);
        int h, m;
        h = p % 128;
        m = h * (128 - h) * 127 / 4096;
        return (p >= 128) ? -m : m;
    endfunction

    function automatic longint cf(input int k, input int mul, input int add);
        shortint s;
        s = shortint'(k * mul + add);
        return longint'(s);
    endfunction

    function automatic logic [39:0] ref_val(input int n);
        longint acc = 0;
        int th = (n * STEP) % 256;
        for (int k = 1; k <= NT; k++) begin
            int ph = (k * th) % 256;
            longint w = cf(k, 911, 5);
            acc += cf(k, 7919, 311) * w * sn((ph + 64) % 256)
                 + cf(k, 4093, 2027) * w * sn(ph);
        end
        return acc[39:0];
    endfunction

    task automatic first_result(input string tag);
        int n = 0;
        @(negedge clk);
        rst = 1'b0;
        en  = 1'b1;
        while (n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (y_valid) break;
        end
        chk(n == 21, "R7", {tag, " first-result latency"}, n, 21);
        chk(y_data == ref_val(0), "R4,R2,R3,R5", {tag, " point 0 value"},
            longint'(y_data), longint'(ref_val(0)));
        last_y = y_data;
        pt     = 1;
        encnt  = 0;
    endtask

    task automatic run_pts(input logic [7:0] mask, input int npts);
        int got = 0;
        int cyc = 0;
        bit prev_v = 1'b0;
        while (got < npts && cyc < 4000) begin
            en = mask[cyc % 8];
            cyc++;
            @(posedge clk);
            if (en) encnt++;
            @(negedge clk);
            if (!en) begin
                chk(!y_valid && y_data == last_y, "R8", "disabled edge changed output",
                    longint'(y_data), longint'(last_y));
            end else if (!y_valid) begin
                chk(y_data == last_y, "R9", "data not held", longint'(y_data), longint'(last_y));
            end
            if (y_valid) begin
                chk(!prev_v, "R6", "pulse longer than one cycle", 1, 0);
                chk(encnt == NT, "R6", "enabled cycles between results", encnt, NT);
                chk(y_data == ref_val(pt), "R4,R5,R8", $sformatf("point %0d value", pt),
                    longint'(y_data), longint'(ref_val(pt)));
                last_y = y_data;
                pt++;
                got++;
                encnt = 0;
            end
            prev_v = y_valid;
        end
        chk(got == npts, "R6", "points collected", got, npts);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!y_valid, "R1", "valid during reset", y_valid, 0);
        chk(y_data == '0, "R1", "data during reset", longint'(y_data), 0);
        first_result("power-up");

        foreach (VEC[i]) run_pts(VEC[i][15:8], int'(VEC[i][7:0]));

        // reset in the middle of a point
        en = 1'b1;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!y_valid, "R1", "valid after mid-run reset", y_valid, 0);
        chk(y_data == '0, "R1", "data after mid-run reset", longint'(y_data), 0);
        first_result("mid-run reset");
        run_pts(8'hFF, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule